// File: doc/BRIEF.md
# TDM Highway Receive Data Serializer

This block takes received frame data one byte per time slot and drives it as a serial bit stream onto a system highway. The system clock may run at 1, 2, 4 or 8 times the highway bit rate. At multiples above one, each bit period is divided into channel phases. The data bit appears only in the one phase chosen by configuration, and the output is actively held at 0 in all the other phases. This lets several serializers share one highway wire.

A sync pulse sets the frame position. A programmable offset, supplied as a low byte and a high part, places the start of time slot 0 a chosen number of clock cycles after the sync edge. While the offset counts down, the current frame keeps running. A sync that repeats at the frame period therefore realigns the frame without a gap in the output. The byte source is asked for each slot's byte in the last cycle before that slot begins. A configuration bit chooses whether the output changes on the rising or on the falling clock edge.

Top module: `tdm_rx_serializer`

## Requirements
- R1: After reset, and until the first frame alignment completes, rdo_o and req_o stay 0.
- R2: Rate code 0, 1, 2 or 3 gives a clock multiple M of 1, 2, 4 or 8. Each highway bit occupies M consecutive cycles, and the phase index of a cycle is its position within the bit, counting 0 to M-1.
- R3: A frame holds 32 time slots of 8 bits each, or 24 slots when cfg_alt_i=1. Slots are sent in ascending order, and the bits of each slot's byte are sent MSB first. The frame wraps from the last slot back to slot 0.
- R4: Let the offset be {cfg_off_hi_i, cfg_off_lo_i}, a value from 0 to 2047. Slot 0, bit 0, phase 0 is driven in the cycle that begins at the (offset+1)-th rising edge after the edge that samples sync_i high.
- R5: Each sync reloads the offset countdown while the running frame continues. When sync repeats at exactly the frame period, the output stays continuous across realignments.
- R6: Data is driven only in cycles whose phase index equals cfg_sel_i, and rdo_o is 0 in every other cycle. If cfg_sel_i is M or greater, rdo_o is always 0.
- R7: With cfg_fall_i=0, rdo_o changes just after the rising edge. With cfg_fall_i=1, the same bit sequence appears half a cycle later and changes on the falling edge.
- R8: req_o is high for exactly one cycle, the last cycle before a slot begins. In that cycle req_slot_o gives the index of that slot and req_frame_o is 1 only when that index is 0. data_i is captured at the rising edge that ends the request cycle.
- R9: When the offset countdown ends in the same cycle as a natural slot boundary, the realignment wins: the request carries slot 0 and slot 0 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame sync pulse, sampled on the rising edge |
| cfg_rate_i | input | 2 | Clock multiple code, M = 2^code |
| cfg_sel_i | input | 3 | Selected channel phase |
| cfg_off_lo_i | input | 8 | Offset, low 8 bits |
| cfg_off_hi_i | input | 3 | Offset, high 3 bits |
| cfg_alt_i | input | 1 | 1: 24-slot frame, 0: 32-slot frame |
| cfg_fall_i | input | 1 | 1: output changes on the falling edge |
| data_i | input | 8 | Byte for the requested slot |
| req_o | output | 1 | Byte request |
| req_slot_o | output | 5 | Slot index of the request |
| req_frame_o | output | 1 | The request is for slot 0 |
| rdo_o | output | 1 | Serial highway data |

## Verification
Two events can fall in the same cycle: the end of the offset countdown, which forces slot 0, and the natural end of a running slot, which would request the next slot. To provoke this, a second sync is timed so that the countdown expires exactly in the request cycle for slot 5 of a running frame. The outcome is judged by expecting slot 0 on req_slot_o, with req_frame_o high, and then the slot 0 byte bit-exact on rdo_o. A second overlap is a sync repeated at the frame period, where the forced restart coincides with the natural frame wrap. For that case the bench checks that the serial stream shows no gap or slip over two frames.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  localparam int unsigned DEF_SLOTS     = 32;
  localparam int unsigned DEF_ALT_SLOTS = 24;
  localparam int unsigned DEF_SLOT_BITS = 8;
  localparam int unsigned DEF_MUL_LOG   = 3;
  localparam int unsigned DEF_OFF_LO_W  = 8;
  localparam int unsigned DEF_OFF_HI_W  = 3;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;

endpackage

// File: rtl/tdm_rx_align.sv
module tdm_rx_align #(
  parameter int unsigned OFF_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic             start_o
);

  logic             armed_q, armed_d;
  logic [OFF_W-1:0] dly_q, dly_d;

  always_comb begin
    armed_d = armed_q;
    dly_d   = dly_q;
    if (sync_i) begin
      armed_d = 1'b1;
      dly_d   = offset_i;
    end else if (armed_q) begin
      if (dly_q == '0) begin
        armed_d = 1'b0;
      end else begin
        dly_d = dly_q - OFF_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      dly_q   <= '0;
    end else begin
      armed_q <= armed_d;
      dly_q   <= dly_d;
    end
  end

  assign start_o = armed_q && (dly_q == '0);

  AST_ALIGN_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> armed_q && (dly_q == $past(offset_i))); // R5

endmodule

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer #(
  parameter int unsigned SLOTS     = 32,
  parameter int unsigned ALT_SLOTS = 24,
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned PH_W      = 3,
  parameter int unsigned RATE_W    = 2,
  localparam int unsigned BIT_W    = $clog2(SLOT_BITS),
  localparam int unsigned SLOT_W   = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              alt_i,
  output logic              run_o,
  output logic [PH_W-1:0]   ph_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              req_o,
  output logic [SLOT_W-1:0] req_slot_o,
  output logic              req_frame_o
);

  logic              run_q, run_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [SLOT_W-1:0] slot_q, slot_d;

  logic [PH_W-1:0]   ph_max;
  logic [SLOT_W-1:0] slot_max;
  logic              ph_last, bit_last, slot_end, frame_end;

  assign ph_max    = PH_W'((32'd1 << rate_i) - 32'd1);
  assign slot_max  = alt_i ? SLOT_W'(ALT_SLOTS - 1) : SLOT_W'(SLOTS - 1);
  assign ph_last   = (ph_q >= ph_max);
  assign bit_last  = (bit_q == BIT_W'(SLOT_BITS - 1));
  assign slot_end  = run_q && ph_last && bit_last;
  assign frame_end = slot_end && (slot_q >= slot_max);

  always_comb begin
    run_d  = run_q;
    ph_d   = ph_q;
    bit_d  = bit_q;
    slot_d = slot_q;
    if (start_i) begin
      run_d  = 1'b1;
      ph_d   = '0;
      bit_d  = '0;
      slot_d = '0;
    end else if (run_q) begin
      if (ph_last) begin
        ph_d = '0;
        if (bit_last) begin
          bit_d  = '0;
          slot_d = frame_end ? '0 : slot_q + SLOT_W'(1);
        end else begin
          bit_d = bit_q + BIT_W'(1);
        end
      end else begin
        ph_d = ph_q + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ph_q   <= '0;
      bit_q  <= '0;
      slot_q <= '0;
    end else begin
      run_q  <= run_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      slot_q <= slot_d;
    end
  end

  assign run_o       = run_q;
  assign ph_o        = ph_q;
  assign bit_o       = bit_q;
  assign req_o       = start_i || slot_end;
  assign req_slot_o  = (start_i || frame_end) ? '0 : slot_q + SLOT_W'(1);
  assign req_frame_o = start_i || frame_end;

  AST_PHASE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !start_i && ph_last |=> (ph_q == '0)); // R2
  AST_FRAME_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end && !start_i |=> (slot_q == '0) && (bit_q == '0)); // R3
  AST_START_ALIGNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> run_q && (ph_q == '0) && (bit_q == '0) && (slot_q == '0)); // R4

endmodule

// File: rtl/tdm_rx_shifter.sv
module tdm_rx_shifter
  import tdm_rx_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned PH_W      = 3,
  parameter int unsigned RATE_W    = 2,
  localparam int unsigned BIT_W    = $clog2(SLOT_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [SLOT_BITS-1:0] data_i,
  input  logic                 run_i,
  input  logic [PH_W-1:0]      ph_i,
  input  logic [BIT_W-1:0]     bit_i,
  input  logic [RATE_W-1:0]    rate_i,
  input  logic [PH_W-1:0]      sel_i,
  input  edge_e                edge_i,
  output logic                 rise_o,
  output logic                 rdo_o
);

  logic [SLOT_BITS-1:0] byte_q, byte_d;
  logic                 fall_q;
  logic [PH_W-1:0]      ph_max;
  logic [BIT_W-1:0]     pick;
  logic                 sel_ok;

  assign byte_d = load_i ? data_i : byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
    end else begin
      byte_q <= byte_d;
    end
  end

  assign ph_max = PH_W'((32'd1 << rate_i) - 32'd1);
  assign sel_ok = (sel_i <= ph_max) && (ph_i == sel_i);
  assign pick   = BIT_W'(SLOT_BITS - 1) - bit_i;
  assign rise_o = run_i && sel_ok && byte_q[pick];

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_q <= 1'b0;
    end else begin
      fall_q <= rise_o;
    end
  end

  assign rdo_o = (edge_i == EDGE_FALL) ? fall_q : rise_o;

  AST_FALL_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_q == rise_o); // R7

endmodule

// File: rtl/tdm_rx_serializer.sv
module tdm_rx_serializer
  import tdm_rx_pkg::*;
#(
  parameter int unsigned SLOTS     = DEF_SLOTS,
  parameter int unsigned ALT_SLOTS = DEF_ALT_SLOTS,
  parameter int unsigned SLOT_BITS = DEF_SLOT_BITS,
  parameter int unsigned MUL_LOG   = DEF_MUL_LOG,
  parameter int unsigned OFF_LO_W  = DEF_OFF_LO_W,
  parameter int unsigned OFF_HI_W  = DEF_OFF_HI_W,
  localparam int unsigned PH_W     = MUL_LOG,
  localparam int unsigned RATE_W   = $clog2(MUL_LOG + 1),
  localparam int unsigned OFF_W    = OFF_LO_W + OFF_HI_W,
  localparam int unsigned BIT_W    = $clog2(SLOT_BITS),
  localparam int unsigned SLOT_W   = $clog2(SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sync_i,
  input  logic [RATE_W-1:0]    cfg_rate_i,
  input  logic [PH_W-1:0]      cfg_sel_i,
  input  logic [OFF_LO_W-1:0]  cfg_off_lo_i,
  input  logic [OFF_HI_W-1:0]  cfg_off_hi_i,
  input  logic                 cfg_alt_i,
  input  logic                 cfg_fall_i,
  input  logic [SLOT_BITS-1:0] data_i,
  output logic                 req_o,
  output logic [SLOT_W-1:0]    req_slot_o,
  output logic                 req_frame_o,
  output logic                 rdo_o
);

  logic              rst_meta_q, rst_q;
  logic              al_start;
  logic              fr_run;
  logic [PH_W-1:0]   fr_ph;
  logic [BIT_W-1:0]  fr_bit;
  logic              sh_rise;
  logic [OFF_W-1:0]  offset;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  assign offset = {cfg_off_hi_i, cfg_off_lo_i};

  tdm_rx_align #(
    .OFF_W (OFF_W)
  ) u_align (
    .clk_i    (clk_i),
    .rst_ni   (rst_q),
    .sync_i   (sync_i),
    .offset_i (offset),
    .start_o  (al_start)
  );

  tdm_rx_framer #(
    .SLOTS     (SLOTS),
    .ALT_SLOTS (ALT_SLOTS),
    .SLOT_BITS (SLOT_BITS),
    .PH_W      (PH_W),
    .RATE_W    (RATE_W)
  ) u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_q),
    .start_i     (al_start),
    .rate_i      (cfg_rate_i),
    .alt_i       (cfg_alt_i),
    .run_o       (fr_run),
    .ph_o        (fr_ph),
    .bit_o       (fr_bit),
    .req_o       (req_o),
    .req_slot_o  (req_slot_o),
    .req_frame_o (req_frame_o)
  );

  tdm_rx_shifter #(
    .SLOT_BITS (SLOT_BITS),
    .PH_W      (PH_W),
    .RATE_W    (RATE_W)
  ) u_shifter (
    .clk_i  (clk_i),
    .rst_ni (rst_q),
    .load_i (req_o),
    .data_i (data_i),
    .run_i  (fr_run),
    .ph_i   (fr_ph),
    .bit_i  (fr_bit),
    .rate_i (cfg_rate_i),
    .sel_i  (cfg_sel_i),
    .edge_i (edge_e'(cfg_fall_i)),
    .rise_o (sh_rise),
    .rdo_o  (rdo_o)
  );

  AST_QUIET_UNTIL_RUN: assert property (@(posedge clk_i) disable iff (!rst_q)
    !fr_run |-> !rdo_o); // R1
  AST_DRIVE_IN_PHASE: assert property (@(posedge clk_i) disable iff (!rst_q)
    sh_rise |-> (fr_ph == cfg_sel_i)); // R6
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_q)
    req_o |=> (!req_o || al_start)); // R8
  AST_LOAD_AT_START: assert property (@(posedge clk_i) disable iff (!rst_q)
    req_o |=> fr_run && (fr_ph == '0) && (fr_bit == '0)); // R8
  AST_FORCED_SLOT0: assert property (@(posedge clk_i) disable iff (!rst_q)
    al_start |-> req_o && (req_slot_o == '0) && req_frame_o); // R9

endmodule

// File: tb/tdm_rx_serializer_tb.sv
module tdm_rx_serializer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 11;

  typedef struct packed {
    logic [1:0]  rate;
    logic [2:0]  sel;
    logic [10:0] off;
    logic        alt;
    logic        fall;
    logic        early;
    logic [7:0]  seed;
    logic [15:0] period;
    logic [15:0] cycles;
    logic [3:0]  tag;
  } vec_t;

  // rate, sel, off, alt, fall, early, seed, sync period, cycles, requirement
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 3'd0, 11'd0,    1'b0, 1'b0, 1'b0, 8'h5A, 16'd0,   16'd256,  4'd3}, // R3
    '{2'd1, 3'd1, 11'd5,    1'b0, 1'b0, 1'b0, 8'hC3, 16'd0,   16'd512,  4'd2}, // R2
    '{2'd2, 3'd3, 11'd37,   1'b1, 1'b1, 1'b0, 8'h17, 16'd0,   16'd768,  4'd3}, // R3 alt
    '{2'd3, 3'd6, 11'd300,  1'b0, 1'b0, 1'b0, 8'h99, 16'd0,   16'd2048, 4'd4}, // R4
    '{2'd3, 3'd0, 11'd2047, 1'b1, 1'b1, 1'b0, 8'h3E, 16'd0,   16'd1536, 4'd4}, // R4 max
    '{2'd1, 3'd5, 11'd3,    1'b0, 1'b0, 1'b0, 8'hF0, 16'd0,   16'd512,  4'd6}, // R6
    '{2'd0, 3'd1, 11'd2,    1'b0, 1'b0, 1'b0, 8'hA5, 16'd0,   16'd300,  4'd6}, // R6
    '{2'd0, 3'd0, 11'd0,    1'b0, 1'b0, 1'b1, 8'h6B, 16'd0,   16'd64,   4'd7}, // R7
    '{2'd0, 3'd0, 11'd0,    1'b0, 1'b1, 1'b1, 8'h6B, 16'd0,   16'd64,   4'd7}, // R7
    '{2'd1, 3'd1, 11'd10,   1'b1, 1'b0, 1'b0, 8'h2D, 16'd384, 16'd800,  4'd5}, // R5
    '{2'd0, 3'd0, 11'd0,    1'b0, 1'b0, 1'b0, 8'h81, 16'd40,  16'd120,  4'd9}  // R9
  };

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       sync_i;
  logic [1:0] cfg_rate_i;
  logic [2:0] cfg_sel_i;
  logic [7:0] cfg_off_lo_i;
  logic [2:0] cfg_off_hi_i;
  logic       cfg_alt_i;
  logic       cfg_fall_i;
  logic [7:0] data_i;
  logic       req_o;
  logic [4:0] req_slot_o;
  logic       req_frame_o;
  logic       rdo_o;
  logic [7:0] seed;

  int n_checks = 0;
  int n_errors = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [7:0] pat(input logic [7:0] s, input logic [4:0] sl);
    return 8'(((32'(sl) * 29) + 32'(s)) ^ (32'(sl) << 3));
  endfunction

  assign data_i = pat(seed, req_slot_o);

  tdm_rx_serializer u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sync_i       (sync_i),
    .cfg_rate_i   (cfg_rate_i),
    .cfg_sel_i    (cfg_sel_i),
    .cfg_off_lo_i (cfg_off_lo_i),
    .cfg_off_hi_i (cfg_off_hi_i),
    .cfg_alt_i    (cfg_alt_i),
    .cfg_fall_i   (cfg_fall_i),
    .data_i       (data_i),
    .req_o        (req_o),
    .req_slot_o   (req_slot_o),
    .req_frame_o  (req_frame_o),
    .rdo_o        (rdo_o)
  );

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Expected serial bit at frame position pos (R2, R3, R6)
  function automatic int exp_bit(input int pos, input int m, input int slots,
                                 input int sel, input logic [7:0] s);
    int p, sl, b, ph;
    logic [7:0] byt;
    p  = pos % (m * 8 * slots);
    sl = p / (8 * m);
    b  = (p / m) % 8;
    ph = p % m;
    byt = pat(s, 5'(sl));
    if (sel >= m || ph != sel) return 0;
    return int'(byt[7 - b]);
  endfunction

  task automatic run_vec(input vec_t v);
    int m, slots, total, pend, start_j, pos, e, er, es;
    bit pend_v, have_start, exp_req;
    logic r_early;
    m     = 1 << v.rate;
    slots = v.alt ? 24 : 32;
    cfg_rate_i   = v.rate;
    cfg_sel_i    = v.sel;
    cfg_off_lo_i = v.off[7:0];
    cfg_off_hi_i = v.off[10:8];
    cfg_alt_i    = v.alt;
    cfg_fall_i   = v.fall;
    seed         = v.seed;
    sync_i       = 1'b1;
    pend   = int'(v.off) + 1;
    pend_v = 1'b1;
    have_start = 1'b0;
    start_j = 0;
    total = int'(v.off) + 1 + int'(v.cycles);
    @(posedge clk_i); #1;
    for (int j = 0; j < total; j++) begin
      sync_i = (v.period != 0) && ((j % int'(v.period)) == int'(v.period) - 1);
      if (sync_i) begin
        pend   = j + int'(v.off) + 2;
        pend_v = 1'b1;
      end
      if (pend_v && j >= pend) begin
        start_j    = pend;
        have_start = 1'b1;
        pend_v     = 1'b0;
      end
      #1;
      r_early = rdo_o;
      #6;
      pos = j - start_j;
      // R8 / R9: request timing, slot index and frame flag
      exp_req = 1'b0;
      es = 0;
      if (pend_v && j == pend - 1) begin
        exp_req = 1'b1;
        es = 0;
      end else if (have_start && ((pos + 1) % (8 * m)) == 0) begin
        exp_req = 1'b1;
        es = ((pos + 1) / (8 * m)) % slots;
      end
      if (have_start || (pend_v && j == pend - 1)) begin
        check(req_o == exp_req, (pend_v && j == pend - 1) ? "R9" : "R8",
              "req_o", int'(req_o), int'(exp_req));
        if (exp_req) begin
          check(int'(req_slot_o) == es, (pend_v && j == pend - 1) ? "R9" : "R8",
                "req_slot_o", int'(req_slot_o), es);
          check(req_frame_o == (es == 0), "R8", "req_frame_o",
                int'(req_frame_o), int'(es == 0));
        end
      end
      if (have_start) begin
        e = exp_bit(pos, m, slots, int'(v.sel), v.seed);
        check(int'(rdo_o) == e, tag_name(int'(v.tag)), "rdo_o", int'(rdo_o), e);
        // R7: just after the rising edge, falling mode still shows the previous bit
        if (v.early && pos >= 1) begin
          er = v.fall ? exp_bit(pos - 1, m, slots, int'(v.sel), v.seed) : e;
          check(int'(r_early) == er, "R7", "rdo_o early", int'(r_early), er);
        end
      end
      @(posedge clk_i); #1;
    end
    sync_i = 1'b0;
  endtask

  initial begin
    rst_ni = 1'b0;
    sync_i = 1'b0;
    cfg_rate_i = '0; cfg_sel_i = '0; cfg_off_lo_i = '0; cfg_off_hi_i = '0;
    cfg_alt_i = 1'b0; cfg_fall_i = 1'b0; seed = 8'h11;
    repeat (4) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1: quiet after reset, no sync yet
    for (int k = 0; k < 40; k++) begin
      @(posedge clk_i); #7;
      check(rdo_o == 1'b0, "R1", "rdo_o idle", int'(rdo_o), 0);
      check(req_o == 1'b0, "R1", "req_o idle", int'(req_o), 0);
    end
    @(posedge clk_i); #1;
    // Vector table walk (R2 R3 R4 R5 R6 R7 R8 R9)
    for (int i = 0; i < NVEC; i++) begin
      run_vec(VECS[i]);
    end
    // R1: reset during a running frame silences the output until a new sync
    #2 rst_ni = 1'b0;
    #1;
    check(rdo_o == 1'b0, "R1", "rdo_o in reset", int'(rdo_o), 0);
    check(req_o == 1'b0, "R1", "req_o in reset", int'(req_o), 0);
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(posedge clk_i); #7;
      check(rdo_o == 1'b0, "R1", "rdo_o after reset", int'(rdo_o), 0);
      check(req_o == 1'b0, "R1", "req_o after reset", int'(req_o), 0);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule